// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Sequencer

This block owns the clock-enable pin and the command pins of a mobile single-data-rate SDRAM while the memory moves between its running state and its low-power states: power down, self refresh, deep power down and clock suspend. A controller asks for one transition at a time over a valid/ready handshake. A bank tracker supplies a flag that is high when every bank is precharged. The sequencer decides whether the request is legal now and drives the entry or exit pattern with the correct clock-enable history. It also issues the two idle-state commands, auto refresh and mode register set, because both share the all-banks-idle rule.

A request that is not legal in the present state is held: ready stays low and the pins do not change until the request becomes legal. All pin outputs are registered. The cycle in which the target state first shows on the pins is marked by a one-cycle `done` pulse. `busy` is high while an exit sequence is still running. The no-operation hold after deep power down is counted in clock cycles, as `CLK_MHZ * DPD_HOLD_US`.

Top module: `sdr_lowpower_seq`

## Requirements
- R1: Reset drives `sd_cke` low, the command pins deselected ({cs_n,ras_n,cas_n,we_n} = 4'b1111), and `busy` and `done` low. The memory then counts as powered down, so only a wake request (`req_kind` = 4) is accepted.
- R2: Power-down (0), self-refresh (1), deep-power-down (2), auto-refresh (5) and mode-register-set (6) requests are accepted only while `banks_idle` is high. Otherwise `req_ready` stays low and the pins keep showing the running no-operation.
- R3: An accepted auto refresh drives `sd_cke` high and command 4'b0001 for one cycle, with `done` high in that cycle. The pins then return to no-operation.
- R4: An accepted mode register set drives command 4'b0000 with `sd_cke` high and `{sd_ba,sd_addr}` equal to `req_opcode`, for one cycle, with `done` high.
- R5: Self-refresh entry lowers `sd_cke` in the same cycle as command 4'b0001, with `done` high. After that, `sd_cke` stays low and the pins are deselected.
- R6: Power-down entry lowers `sd_cke` with the pins deselected and `done` high. `sd_cke` stays low, deselected, until a wake request.
- R7: A clock-suspend request (3) is accepted only while `banks_idle` is low. It lowers `sd_cke` with `done` high and keeps it low until a wake request.
- R8: Wake from power down, self refresh or clock suspend raises `sd_cke` together with a no-operation (4'b0111) and `busy` high. One cycle later, `done` pulses while the no-operation continues, and `req_ready` is low in between.
- R9: Deep-power-down entry lowers `sd_cke` in the same cycle as command 4'b0110, with `done` high.
- R10: Wake from deep power down raises `sd_cke` and holds a no-operation with `busy` high, and no request accepted, for exactly `CLK_MHZ*DPD_HOLD_US` cycles. `done` follows in the next cycle.
- R11: While `sd_cke` is low, every request other than wake is held with `req_ready` low and leaves the pins unchanged.
- R12: `done` and `busy` are never high in the same cycle.
- R13: Whenever `sd_cke` is high and no command is being issued, the pins show the no-operation 4'b0111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request legal and accepted this cycle |
| req_kind | input | 3 | 0 power down, 1 self refresh, 2 deep power down, 3 suspend, 4 wake, 5 auto refresh, 6 mode register set |
| req_opcode | input | BA_W+ADDR_W | Mode register opcode; bank bits on top |
| banks_idle | input | 1 | All banks precharged |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Address / opcode |
| busy | output | 1 | Exit sequence in progress |
| done | output | 1 | Target state reached (one cycle) |

## Verification
Two events can fall in the same cycle: the bank-idle flag changing and a pending power-down request being accepted. The bench holds a power-down request while the flag is low, checks that the pins stay at no-operation, then raises the flag at the same edge the request is sampled. The entry pattern must appear in the very next cycle. In the same way, a request presented during the single wake no-operation cycle, or during the long deep-power-down hold, must wait until `done` has been seen. The bench judges this by comparing the pins cycle by cycle against a queue of expected values.

// File: rtl/lpseq_pkg.sv
package lpseq_pkg;

    typedef enum logic [2:0] {
        REQ_PDN  = 3'd0,
        REQ_SREF = 3'd1,
        REQ_DPD  = 3'd2,
        REQ_SUSP = 3'd3,
        REQ_WAKE = 3'd4,
        REQ_AREF = 3'd5,
        REQ_MRS  = 3'd6
    } req_e;

    typedef enum logic [2:0] {
        PS_RUN, PS_PDN, PS_SREF, PS_DPD, PS_SUSP, PS_WAKE_NOP, PS_DPD_HOLD
    } pstate_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_t;

    typedef struct packed {
        logic cke;
        cmd_t cmd;
        logic busy;
        logic done;
    } pins_t;

    localparam cmd_t CMD_NOP   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam cmd_t CMD_DESEL = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam cmd_t CMD_REF   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam cmd_t CMD_MRS   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
    localparam cmd_t CMD_DPD   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};

    function automatic int hold_cycles(input int mhz, input int us);
        return mhz * us;
    endfunction

    function automatic logic is_low_power(input pstate_e st);
        return (st == PS_PDN) || (st == PS_SREF) || (st == PS_DPD) || (st == PS_SUSP);
    endfunction

    function automatic logic req_legal(input pstate_e st, input req_e k, input logic idle);
        logic ok;
        ok = 1'b0;
        if (st == PS_RUN) begin
            case (k)
                REQ_PDN, REQ_SREF, REQ_DPD, REQ_AREF, REQ_MRS: ok = idle;
                REQ_SUSP: ok = !idle;
                default:  ok = 1'b0;
            endcase
        end else if (is_low_power(st)) begin
            ok = (k == REQ_WAKE);
        end
        return ok;
    endfunction

endpackage

// File: rtl/lpseq_hold_timer.sv
module lpseq_hold_timer #(
    parameter int HOLD = 20000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic zero
);
    localparam int CNT_W = (HOLD > 1) ? $clog2(HOLD + 1) : 1;
    localparam logic [CNT_W-1:0] START = CNT_W'(HOLD - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= START;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/lpseq_ctrl.sv
module lpseq_ctrl
    import lpseq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req_valid,
    input  logic [2:0] req_kind,
    input  logic    banks_idle,
    input  logic    tmr_zero,
    output logic    req_ready,
    output logic    tmr_load,
    output logic    tmr_run,
    output logic    addr_load,
    output pins_t   pins_nxt
);
    pstate_e state, state_nxt;
    req_e    kind;
    logic    accept;

    assign kind      = req_e'(req_kind);
    assign req_ready = req_legal(state, kind, banks_idle);
    assign accept    = req_valid && req_ready;

    always_comb begin
        state_nxt     = state;
        tmr_load      = 1'b0;
        tmr_run       = 1'b0;
        addr_load     = 1'b0;
        pins_nxt.cke  = !is_low_power(state);
        pins_nxt.cmd  = is_low_power(state) ? CMD_DESEL : CMD_NOP;
        pins_nxt.busy = 1'b0;
        pins_nxt.done = 1'b0;
        case (state)
            PS_RUN: begin
                if (accept) begin
                    pins_nxt.done = 1'b1;
                    case (kind)
                        REQ_PDN: begin
                            state_nxt    = PS_PDN;
                            pins_nxt.cke = 1'b0;
                            pins_nxt.cmd = CMD_DESEL;
                        end
                        REQ_SREF: begin
                            state_nxt    = PS_SREF;
                            pins_nxt.cke = 1'b0;
                            pins_nxt.cmd = CMD_REF;
                        end
                        REQ_DPD: begin
                            state_nxt    = PS_DPD;
                            pins_nxt.cke = 1'b0;
                            pins_nxt.cmd = CMD_DPD;
                        end
                        REQ_SUSP: begin
                            state_nxt    = PS_SUSP;
                            pins_nxt.cke = 1'b0;
                            pins_nxt.cmd = CMD_DESEL;
                        end
                        REQ_AREF: pins_nxt.cmd = CMD_REF;
                        REQ_MRS: begin
                            pins_nxt.cmd = CMD_MRS;
                            addr_load    = 1'b1;
                        end
                        default: pins_nxt.done = 1'b0;
                    endcase
                end
            end
            PS_PDN, PS_SREF, PS_SUSP: begin
                if (accept) begin
                    state_nxt     = PS_WAKE_NOP;
                    pins_nxt.cke  = 1'b1;
                    pins_nxt.cmd  = CMD_NOP;
                    pins_nxt.busy = 1'b1;
                end
            end
            PS_DPD: begin
                if (accept) begin
                    state_nxt     = PS_DPD_HOLD;
                    tmr_load      = 1'b1;
                    pins_nxt.cke  = 1'b1;
                    pins_nxt.cmd  = CMD_NOP;
                    pins_nxt.busy = 1'b1;
                end
            end
            PS_WAKE_NOP: begin
                state_nxt     = PS_RUN;
                pins_nxt.done = 1'b1;
            end
            PS_DPD_HOLD: begin
                tmr_run = 1'b1;
                if (tmr_zero) begin
                    state_nxt     = PS_RUN;
                    pins_nxt.done = 1'b1;
                end else begin
                    pins_nxt.busy = 1'b1;
                end
            end
            default: state_nxt = PS_PDN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PS_PDN;
        else     state <= state_nxt;
    end
endmodule

// File: rtl/lpseq_pin_reg.sv
module lpseq_pin_reg
    import lpseq_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  pins_t                  pins_nxt,
    input  logic                   addr_load,
    input  logic [BA_W+ADDR_W-1:0] opcode,
    output pins_t                  pins_q,
    output logic [BA_W-1:0]        ba_q,
    output logic [ADDR_W-1:0]      addr_q
);
    localparam pins_t RESET_PINS = '{cke: 1'b0, cmd: CMD_DESEL, busy: 1'b0, done: 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q <= RESET_PINS;
            ba_q   <= '0;
            addr_q <= '0;
        end else begin
            pins_q <= pins_nxt;
            if (addr_load) begin
                {ba_q, addr_q} <= opcode;
            end else begin
                ba_q   <= '0;
                addr_q <= '0;
            end
        end
    end
endmodule

// File: rtl/sdr_lowpower_seq.sv
module sdr_lowpower_seq
    import lpseq_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int BA_W        = 2,
    parameter int CLK_MHZ     = 100,
    parameter int DPD_HOLD_US = 200
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [2:0]             req_kind,
    input  logic [BA_W+ADDR_W-1:0] req_opcode,
    input  logic                   banks_idle,
    output logic                   sd_cke,
    output logic                   sd_cs_n,
    output logic                   sd_ras_n,
    output logic                   sd_cas_n,
    output logic                   sd_we_n,
    output logic [BA_W-1:0]        sd_ba,
    output logic [ADDR_W-1:0]      sd_addr,
    output logic                   busy,
    output logic                   done
);
    localparam int HOLD = hold_cycles(CLK_MHZ, DPD_HOLD_US);

    pins_t pins_nxt, pins_q;
    logic  tmr_load, tmr_run, tmr_zero, addr_load;

    lpseq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_kind   (req_kind),
        .banks_idle (banks_idle),
        .tmr_zero   (tmr_zero),
        .req_ready  (req_ready),
        .tmr_load   (tmr_load),
        .tmr_run    (tmr_run),
        .addr_load  (addr_load),
        .pins_nxt   (pins_nxt)
    );

    lpseq_hold_timer #(.HOLD(HOLD)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .run  (tmr_run),
        .zero (tmr_zero)
    );

    lpseq_pin_reg #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_pins (
        .clk       (clk),
        .rst       (rst),
        .pins_nxt  (pins_nxt),
        .addr_load (addr_load),
        .opcode    (req_opcode),
        .pins_q    (pins_q),
        .ba_q      (sd_ba),
        .addr_q    (sd_addr)
    );

    assign sd_cke   = pins_q.cke;
    assign sd_cs_n  = pins_q.cmd.cs_n;
    assign sd_ras_n = pins_q.cmd.ras_n;
    assign sd_cas_n = pins_q.cmd.cas_n;
    assign sd_we_n  = pins_q.cmd.we_n;
    assign busy     = pins_q.busy;
    assign done     = pins_q.done;
endmodule

// File: rtl/lpseq_checks.sv
module lpseq_checks
    import lpseq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       req_ready,
    input logic [2:0] req_kind,
    input logic       banks_idle,
    input logic       sd_cke,
    input logic       sd_cs_n,
    input logic       sd_ras_n,
    input logic       sd_cas_n,
    input logic       sd_we_n,
    input logic       busy,
    input logic       done
);
    logic [3:0] cmd;
    assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    AST_REF_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0001) |-> $past(banks_idle)); // R2

    AST_SREF_ON_CKE_FALL: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0001 && !sd_cke) |-> $past(sd_cke)); // R5

    AST_LOW_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        (!sd_cke && !$past(sd_cke)) |-> (cmd == 4'b1111)); // R6

    AST_WAKE_NOP: assert property (@(posedge clk) disable iff (rst)
        $rose(sd_cke) |-> (cmd == 4'b0111)); // R8

    AST_HOLD_NOP: assert property (@(posedge clk) disable iff (rst)
        busy |-> (sd_cke && cmd == 4'b0111 && !req_ready)); // R10

    AST_LOW_WAKE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (!sd_cke && req_ready) |-> (req_kind == REQ_WAKE)); // R11

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R12
endmodule

bind sdr_lowpower_seq lpseq_checks u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .req_kind   (req_kind),
    .banks_idle (banks_idle),
    .sd_cke     (sd_cke),
    .sd_cs_n    (sd_cs_n),
    .sd_ras_n   (sd_ras_n),
    .sd_cas_n   (sd_cas_n),
    .sd_we_n    (sd_we_n),
    .busy       (busy),
    .done       (done)
);

// File: tb/sdr_lowpower_seq_bench.sv
module sdr_lowpower_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 13;
    localparam int BA_W       = 2;
    localparam int MHZ        = 1;
    localparam int HOLD_US    = 200;
    localparam int HOLD       = MHZ * HOLD_US;

    localparam logic [3:0] NOP = 4'b0111, DESEL = 4'b1111, REF = 4'b0001,
                           MRS = 4'b0000, DPD = 4'b0110;
    localparam logic [2:0] K_PDN = 3'd0, K_SREF = 3'd1, K_DPD = 3'd2, K_SUSP = 3'd3,
                           K_WAKE = 3'd4, K_AREF = 3'd5, K_MRS = 3'd6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [2:0] req_kind = 3'd0;
    logic [BA_W+ADDR_W-1:0] req_opcode = '0;
    logic banks_idle = 1'b1;
    logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, busy, done;
    logic [BA_W-1:0] sd_ba;
    logic [ADDR_W-1:0] sd_addr;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        int       due;
        bit       cke;
        bit [3:0] cmd;
        bit       done;
        bit       busy;
        string    tag;
    } exp_t;
    exp_t q[$];

    sdr_lowpower_seq #(.ADDR_W(ADDR_W), .BA_W(BA_W), .CLK_MHZ(MHZ), .DPD_HOLD_US(HOLD_US))
    u_sdr_lowpower_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_opcode(req_opcode), .banks_idle(banks_idle),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [3:0] pins_cmd();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    task automatic check(input bit ok, input string tag, input string got, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %s expected %s", tag, got, exp);
        end
    endtask

    task automatic push(input int dly, input bit cke, input bit [3:0] cmd,
                        input bit dn, input bit bs, input string tag);
        exp_t e;
        e.due = cyc + dly; e.cke = cke; e.cmd = cmd; e.done = dn; e.busy = bs; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_ready(input bit exp, input string tag);
        #1;
        check(req_ready == exp, tag, $sformatf("ready=%0b", req_ready), $sformatf("ready=%0b", exp));
    endtask

    task automatic present(input logic [2:0] k);
        req_valid = 1'b1;
        req_kind  = k;
    endtask

    task automatic wake(input string tag);
        present(K_WAKE);
        check_ready(1'b1, tag);
        push(1, 1'b1, NOP, 1'b0, 1'b1, tag);
        push(2, 1'b1, NOP, 1'b1, 1'b0, tag);
        step();
        req_valid = 1'b0;
        check_ready(1'b0, tag);
        step();
    endtask

    // monitor: compares pins against the scoreboard at each falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0 && q[0].due <= cyc) begin
                exp_t e;
                e = q.pop_front();
                check(e.due == cyc && sd_cke == e.cke && pins_cmd() == e.cmd &&
                      done == e.done && busy == e.busy, e.tag,
                      $sformatf("cyc=%0d cke=%0b cmd=%b done=%0b busy=%0b",
                                cyc, sd_cke, pins_cmd(), done, busy),
                      $sformatf("cyc=%0d cke=%0b cmd=%b done=%0b busy=%0b",
                                e.due, e.cke, e.cmd, e.done, e.busy));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(sd_cke == 1'b0 && pins_cmd() == DESEL && !busy && !done, "R1",
              $sformatf("cke=%0b cmd=%b busy=%0b done=%0b", sd_cke, pins_cmd(), busy, done),
              "cke=0 cmd=1111 busy=0 done=0");
        rst = 1'b0;
        step();
        present(K_AREF);
        check_ready(1'b0, "R1");
        req_valid = 1'b0;

        wake("R8");
        push(1, 1'b1, NOP, 1'b0, 1'b0, "R13");
        step();

        // R2: power down held while banks busy, then idle rises on the sampling edge
        banks_idle = 1'b0;
        present(K_PDN);
        check_ready(1'b0, "R2");
        for (int i = 1; i <= 3; i++) push(i, 1'b1, NOP, 1'b0, 1'b0, "R2");
        repeat (3) step();
        banks_idle = 1'b1;
        check_ready(1'b1, "R2");
        push(1, 1'b0, DESEL, 1'b1, 1'b0, "R6");
        push(2, 1'b0, DESEL, 1'b0, 1'b0, "R6");
        step();
        req_valid = 1'b0;
        step();

        // R11: non-wake request ignored in power down
        present(K_AREF);
        check_ready(1'b0, "R11");
        push(1, 1'b0, DESEL, 1'b0, 1'b0, "R11");
        push(2, 1'b0, DESEL, 1'b0, 1'b0, "R11");
        repeat (2) step();
        req_valid = 1'b0;
        wake("R8");

        // R3: auto refresh
        present(K_AREF);
        check_ready(1'b1, "R3");
        push(1, 1'b1, REF, 1'b1, 1'b0, "R3");
        push(2, 1'b1, NOP, 1'b0, 1'b0, "R13");
        step();
        req_valid = 1'b0;
        step();

        // R4: mode register set
        req_opcode = 15'h52A5;
        present(K_MRS);
        check_ready(1'b1, "R4");
        push(1, 1'b1, MRS, 1'b1, 1'b0, "R4");
        step();
        req_valid = 1'b0;
        check({sd_ba, sd_addr} == 15'h52A5, "R4",
              $sformatf("opc=%h", {sd_ba, sd_addr}), "opc=52a5");
        step();

        // R5: self refresh
        present(K_SREF);
        check_ready(1'b1, "R5");
        push(1, 1'b0, REF, 1'b1, 1'b0, "R5");
        push(2, 1'b0, DESEL, 1'b0, 1'b0, "R5");
        step();
        req_valid = 1'b0;
        step();
        wake("R8");

        // R7: suspend needs an open bank
        present(K_SUSP);
        check_ready(1'b0, "R7");
        banks_idle = 1'b0;
        check_ready(1'b1, "R7");
        push(1, 1'b0, DESEL, 1'b1, 1'b0, "R7");
        push(2, 1'b0, DESEL, 1'b0, 1'b0, "R7");
        step();
        req_valid = 1'b0;
        step();
        wake("R8");
        banks_idle = 1'b1;

        // R9 / R10: deep power down and its long exit hold
        present(K_DPD);
        check_ready(1'b1, "R9");
        push(1, 1'b0, DPD, 1'b1, 1'b0, "R9");
        push(2, 1'b0, DESEL, 1'b0, 1'b0, "R9");
        step();
        req_valid = 1'b0;
        step();
        present(K_WAKE);
        check_ready(1'b1, "R10");
        for (int i = 1; i <= HOLD; i++) push(i, 1'b1, NOP, 1'b0, 1'b1, "R10");
        push(HOLD + 1, 1'b1, NOP, 1'b1, 1'b0, "R12");
        step();
        present(K_AREF);
        check_ready(1'b0, "R10");
        repeat (HOLD - 1) step();
        check_ready(1'b0, "R10");
        step();
        check_ready(1'b1, "R10");
        req_valid = 1'b0;

        repeat (3) step();
        check(q.size() == 0, "R12", $sformatf("pending=%0d", q.size()), "pending=0");
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule